// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request of a small microcontroller subsystem into one system reset running on the system clock. Eight causes feed it: power-on, supply-voltage monitor, missing-clock detector, watchdog timeout, a software strobe, an illegal flash-operation fault, a comparator trip, and an active-low external reset pin. The missing-clock and comparator requests count only when their own enable inputs are high.

Any request asserts the system reset at once, with no clock edge needed. Release is synchronous. The reset stays high for a minimum hold count after the last request goes away. It then waits for the selected clock to report that it is stable, so the core always restarts at its reset vector on a settled clock. The controller drives the external reset pin low only for power-on and supply-monitor resets. A sticky cause register keeps a record of what caused the latest reset.

While reset is held, the controller tells the neighbouring blocks to load their defaults. The port latches go to all ones in open-drain mode. The clock select points at the internal oscillator. The watchdog is enabled and counts on the system clock divided by 12. Weak pull-ups stay on at all times. Data memory has no connection to the block and is never cleared by it.

Top module: `rst_controller`

## Requirements
- R1: Raising any enabled hardware request drives `sys_rst_o` high before the next rising clock edge.
- R2: With `clk_stable_i` high, `sys_rst_o` falls on the 19th rising edge after the last hardware request drops (HOLD=16 plus a two-flop synchronizer and the release register). After a software strobe it falls on the 18th rising edge after the strobe drops.
- R3: `sys_rst_o` is never released while `clk_stable_i` is low. If the hold count has already expired, it is released on the first rising edge at which `clk_stable_i` is high.
- R4: A missing-clock request with `mclk_en_i` low, and a comparator request with `cmp_en_i` low, cause no reset and leave `rst_flags_o` unchanged.
- R5: `pin_drive_o` is high only during resets caused by power-on or the supply monitor, and it stays high until `sys_rst_o` is released. While the controller drives the pin, the low level seen on `pin_n_i` is not taken as a pin request.
- R6: The bits of `rst_flags_o` are: bit 0 power-on, bit 1 supply monitor, bit 2 missing clock, bit 3 watchdog, bit 4 software, bit 5 flash fault, bit 6 comparator, bit 7 external pin. A reset that starts from the running state replaces the flags with the set of sources active on its first cycle. Sources that arrive while the reset is still held are added to the flags. The flags do not change while the system is running.
- R7: A power-on request sets `rst_flags_o` to 0x01, whatever it held before.
- R8: `sw_rst_wr_i` is a write strobe to a self-clearing bit. When it is high at a rising edge, `sys_rst_o` is high after that edge.
- R9: While `sys_rst_o` is high, `dflt_load_o` and `port_force_o` are high, and they are low once it is released. The default codes are always presented: `clk_sel_o`=0 (internal oscillator), `wdt_en_o`=1, `wdt_div12_o`=1, `weak_pu_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on request, active high, asynchronous |
| vmon_i | input | 1 | Supply-monitor request, active high, asynchronous |
| mclk_i | input | 1 | Missing-clock detector request |
| mclk_en_i | input | 1 | Enable for the missing-clock request |
| wdt_i | input | 1 | Watchdog timeout request |
| sw_rst_wr_i | input | 1 | Write strobe setting the self-clearing software reset bit |
| flash_err_i | input | 1 | Illegal flash-operation request |
| cmp_i | input | 1 | Comparator trip request |
| cmp_en_i | input | 1 | Enable for the comparator request |
| pin_n_i | input | 1 | Level sensed on the external reset pin, active low |
| clk_stable_i | input | 1 | Selected system clock is stable |
| sys_rst_o | output | 1 | Merged system reset, active high |
| pin_drive_o | output | 1 | Pull the external reset pin low |
| rst_flags_o | output | 8 | Sticky reset-cause flags |
| dflt_load_o | output | 1 | Neighbouring registers load their defaults |
| port_force_o | output | 1 | Port latches forced to all ones, open-drain |
| weak_pu_o | output | 1 | Weak pull-up enable |
| clk_sel_o | output | 1 | Default clock select, 0 = internal oscillator |
| wdt_en_o | output | 1 | Default watchdog enable |
| wdt_div12_o | output | 1 | Default watchdog clock = system clock / 12 |

## Verification
Assertion is combinational, so the bench checks `sys_rst_o` 1 ns after it raises a request, well before the next clock edge. Release has a latency of 19 rising edges after a hardware request drops, 18 after a software strobe, or the first edge with `clk_stable_i` high. A driver records the edge count at the moment of the drop and queues the expected latency, flags and pin-drive history. A monitor sampling on falling edges pops that entry at the first low `sys_rst_o` and compares the measured edge count exactly. Requests that must be ignored are checked at the falling edges while they are applied, and the flags are read back afterwards.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NSRC = 8;

  localparam int SRC_POR   = 0;
  localparam int SRC_VMON  = 1;
  localparam int SRC_MCLK  = 2;
  localparam int SRC_WDT   = 3;
  localparam int SRC_SW    = 4;
  localparam int SRC_FLASH = 5;
  localparam int SRC_CMP   = 6;
  localparam int SRC_PIN   = 7;

  typedef logic [NSRC-1:0] src_vec_t;

  localparam src_vec_t POR_ONLY = src_vec_t'(1) << SRC_POR;

  localparam logic CLK_SEL_INTERNAL = 1'b0;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] req_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    logic raw_b;
    assign raw_b = raw_i[g];
    // asynchronous assertion, release through two flops
    always_ff @(posedge clk_i or posedge raw_b) begin
      if (raw_b) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= 1'b0;
        s2_q <= s1_q;
      end
    end
    assign req_o[g] = s2_q;
  end
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
  parameter int HOLD = 16
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic any_req_i,
  input  logic clk_stable_i,
  output logic rst_q_o,
  output logic release_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  assign release_o = rst_q && !any_req_i && (cnt_q == HOLD_C) && clk_stable_i;
  assign rst_q_o   = rst_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (any_req_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q) begin
      if (cnt_q != HOLD_C) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (clk_stable_i) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
  import rstc_pkg::*;
(
  input  logic     clk_i,
  input  logic     por_i,
  input  src_vec_t req_i,
  input  logic     in_rst_i,
  output src_vec_t flags_o
);
  src_vec_t flags_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      flags_q <= POR_ONLY;
    end else if (req_i[SRC_POR]) begin
      flags_q <= POR_ONLY;
    end else if (|req_i) begin
      flags_q <= in_rst_i ? (flags_q | req_i) : req_i;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rst_controller.sv
module rst_controller
  import rstc_pkg::*;
#(
  parameter int HOLD = 16
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             vmon_i,
  input  logic             mclk_i,
  input  logic             mclk_en_i,
  input  logic             wdt_i,
  input  logic             sw_rst_wr_i,
  input  logic             flash_err_i,
  input  logic             cmp_i,
  input  logic             cmp_en_i,
  input  logic             pin_n_i,
  input  logic             clk_stable_i,
  output logic             sys_rst_o,
  output logic             pin_drive_o,
  output logic [NSRC-1:0]  rst_flags_o,
  output logic             dflt_load_o,
  output logic             port_force_o,
  output logic             weak_pu_o,
  output logic             clk_sel_o,
  output logic             wdt_en_o,
  output logic             wdt_div12_o
);
  src_vec_t raw, req_sync, req;
  logic     sw_q, drive_q, any_req, rst_q, release_p, pin_mask;

  // software bit: set by the strobe, clears itself one cycle later
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) sw_q <= 1'b0;
    else       sw_q <= sw_rst_wr_i;
  end

  // the controller's own pin drive must not read back as a pin request
  assign pin_mask = drive_q | req_sync[SRC_POR] | req_sync[SRC_VMON];

  always_comb begin
    raw            = '0;
    raw[SRC_POR]   = por_i;
    raw[SRC_VMON]  = vmon_i;
    raw[SRC_MCLK]  = mclk_i & mclk_en_i;
    raw[SRC_WDT]   = wdt_i;
    raw[SRC_FLASH] = flash_err_i;
    raw[SRC_CMP]   = cmp_i & cmp_en_i;
    raw[SRC_PIN]   = ~pin_n_i & ~pin_mask;
  end

  rstc_sync #(.W(NSRC)) u_sync (
    .clk_i (clk_i),
    .raw_i (raw),
    .req_o (req_sync)
  );

  always_comb begin
    req         = req_sync;
    req[SRC_SW] = sw_q;
  end

  assign any_req = |req;

  rstc_hold #(.HOLD(HOLD)) u_hold (
    .clk_i        (clk_i),
    .por_i        (por_i),
    .any_req_i    (any_req),
    .clk_stable_i (clk_stable_i),
    .rst_q_o      (rst_q),
    .release_o    (release_p)
  );

  rstc_flags u_flags (
    .clk_i    (clk_i),
    .por_i    (por_i),
    .req_i    (req),
    .in_rst_i (rst_q),
    .flags_o  (rst_flags_o)
  );

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                                        drive_q <= 1'b1;
    else if (req[SRC_POR] || req[SRC_VMON])           drive_q <= 1'b1;
    else if (release_p)                               drive_q <= 1'b0;
  end

  assign sys_rst_o    = rst_q | any_req;
  assign pin_drive_o  = pin_mask;
  assign dflt_load_o  = sys_rst_o;
  assign port_force_o = sys_rst_o;
  assign weak_pu_o    = 1'b1;
  assign clk_sel_o    = CLK_SEL_INTERNAL;
  assign wdt_en_o     = 1'b1;
  assign wdt_div12_o  = 1'b1;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter int HOLD = 16
) (
  input logic       clk_i,
  input logic       por_i,
  input logic       vmon_i,
  input logic       mclk_i,
  input logic       mclk_en_i,
  input logic       wdt_i,
  input logic       sw_rst_wr_i,
  input logic       flash_err_i,
  input logic       cmp_i,
  input logic       cmp_en_i,
  input logic       pin_n_i,
  input logic       clk_stable_i,
  input logic       sys_rst_o,
  input logic       pin_drive_o,
  input logic [7:0] rst_flags_o
);
  logic raw_any;
  int   quiet_q;

  assign raw_any = vmon_i | (mclk_i & mclk_en_i) | wdt_i | sw_rst_wr_i |
                   flash_err_i | (cmp_i & cmp_en_i) | (~pin_n_i & ~pin_drive_o);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)              quiet_q <= 0;
    else if (raw_any)       quiet_q <= 0;
    else if (quiet_q < 1000) quiet_q <= quiet_q + 1;
  end

  assert_hold_window_R2: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(sys_rst_o) |-> (quiet_q >= HOLD));

  assert_release_stable_R3: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(sys_rst_o) |-> $past(clk_stable_i));

  assert_pin_in_reset_R5: assert property (@(posedge clk_i) disable iff (por_i)
    pin_drive_o |-> sys_rst_o);

  assert_flags_frozen_R6: assert property (@(posedge clk_i) disable iff (por_i)
    (!sys_rst_o && $past(!sys_rst_o)) |-> $stable(rst_flags_o));

  assert_sw_entry_R8: assert property (@(posedge clk_i) disable iff (por_i)
    sw_rst_wr_i |=> sys_rst_o);
endmodule

bind rst_controller rstc_checker #(.HOLD(HOLD)) u_rstc_checker (
  .clk_i        (clk_i),
  .por_i        (por_i),
  .vmon_i       (vmon_i),
  .mclk_i       (mclk_i),
  .mclk_en_i    (mclk_en_i),
  .wdt_i        (wdt_i),
  .sw_rst_wr_i  (sw_rst_wr_i),
  .flash_err_i  (flash_err_i),
  .cmp_i        (cmp_i),
  .cmp_en_i     (cmp_en_i),
  .pin_n_i      (pin_n_i),
  .clk_stable_i (clk_stable_i),
  .sys_rst_o    (sys_rst_o),
  .pin_drive_o  (pin_drive_o),
  .rst_flags_o  (rst_flags_o)
);

// File: tb/tb_rst_controller.sv
module tb_rst_controller;
  localparam int HOLD  = 16;
  localparam int LAT_HW = HOLD + 3;
  localparam int LAT_SW = HOLD + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] src;
  logic sw_wr, mclk_en, cmp_en, stable, pin_n;
  logic sys_rst, pin_drive, dflt_load, port_force, weak_pu, clk_sel, wdt_en, wdt_div12;
  logic [7:0] flags;

  assign pin_n = pin_drive ? 1'b0 : ~src[7];

  rst_controller #(.HOLD(HOLD)) dut (
    .clk_i(clk), .por_i(src[0]), .vmon_i(src[1]), .mclk_i(src[2]), .mclk_en_i(mclk_en),
    .wdt_i(src[3]), .sw_rst_wr_i(sw_wr), .flash_err_i(src[5]), .cmp_i(src[6]),
    .cmp_en_i(cmp_en), .pin_n_i(pin_n), .clk_stable_i(stable),
    .sys_rst_o(sys_rst), .pin_drive_o(pin_drive), .rst_flags_o(flags),
    .dflt_load_o(dflt_load), .port_force_o(port_force), .weak_pu_o(weak_pu),
    .clk_sel_o(clk_sel), .wdt_en_o(wdt_en), .wdt_div12_o(wdt_div12)
  );

  typedef struct {
    logic [7:0] flags;
    logic       pin;
    int         lat;
    int         drop;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;
  int   cyc = 0;
  int   n_vec = 0, n_bad = 0;
  logic prev_rst = 1'b1;
  logic pin_seen = 1'b0;
  bit   finished = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the expected release when the reset falls
  always @(negedge clk) begin
    if (sys_rst) pin_seen = pin_seen | pin_drive;
    if (prev_rst && !sys_rst) begin
      if (sbq.size() == 0) begin
        check(0, "R2", "unexpected release", 0, 1);
      end else begin
        cur = sbq.pop_front();
        check(cyc - cur.drop == cur.lat, "R2", "release latency", cyc - cur.drop, cur.lat);
        check(flags == cur.flags, "R6", "cause flags", flags, cur.flags);
        check(pin_seen == cur.pin, "R5", "pin drive history", pin_seen, cur.pin);
        check(!pin_drive, "R5", "pin drive after release", pin_drive, 0);
        check(!port_force && !dflt_load, "R9", "defaults released", {port_force, dflt_load}, 0);
      end
      pin_seen = 1'b0;
    end
    prev_rst = sys_rst;
  end

  task automatic wait_idle();
    while (sbq.size() != 0 || sys_rst) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] f, input logic p, input int lat);
    exp_t e;
    e.flags = f; e.pin = p; e.lat = lat; e.drop = cyc;
    sbq.push_back(e);
  endtask

  // driver: raise sources, check asynchronous entry, drop, queue expectation
  task automatic fire(input logic [7:0] mask, input int len,
                      input logic [7:0] f, input logic p, input string tag);
    @(negedge clk);
    src = mask;
    #1;
    check(sys_rst == 1'b1, "R1", {"async entry ", tag}, sys_rst, 1);
    repeat (len) @(negedge clk);
    src = 8'h00;
    push(f, p, LAT_HW);
    wait_idle();
  endtask

  initial begin
    src = 8'h01; sw_wr = 0; mclk_en = 1; cmp_en = 1; stable = 1;
    #5;
    check(sys_rst == 1'b1, "R1", "power-on reset state", sys_rst, 1);
    check(pin_drive == 1'b1, "R5", "pin driven at power-on", pin_drive, 1);
    check(flags == 8'h01, "R7", "power-on flags", flags, 8'h01);
    check(port_force && dflt_load, "R9", "defaults forced", {port_force, dflt_load}, 3);
    check({clk_sel, wdt_en, wdt_div12, weak_pu} == 4'b0111, "R9", "default codes",
          {clk_sel, wdt_en, wdt_div12, weak_pu}, 4'b0111);
    repeat (4) @(negedge clk);
    src = 8'h00;
    push(8'h01, 1'b1, LAT_HW);
    wait_idle();

    fire(8'h08, 2, 8'h08, 1'b0, "watchdog");
    fire(8'h02, 3, 8'h02, 1'b1, "supply monitor");
    fire(8'h04, 2, 8'h04, 1'b0, "missing clock");
    fire(8'h20, 1, 8'h20, 1'b0, "flash fault");
    fire(8'h40, 2, 8'h40, 1'b0, "comparator");
    fire(8'h80, 3, 8'h80, 1'b0, "external pin");
    fire(8'h28, 2, 8'h28, 1'b0, "watchdog plus flash");

    // R8 software strobe
    @(negedge clk); sw_wr = 1;
    @(negedge clk); sw_wr = 0;
    check(sys_rst == 1'b1, "R8", "software entry", sys_rst, 1);
    push(8'h10, 1'b0, LAT_SW);
    wait_idle();

    // R4 disabled sources are ignored
    mclk_en = 0; cmp_en = 0;
    @(negedge clk); src = 8'h44;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(sys_rst == 1'b0, "R4", "gated source reset", sys_rst, 0);
    end
    src = 8'h00;
    repeat (4) @(negedge clk);
    check(sys_rst == 1'b0, "R4", "gated source late reset", sys_rst, 0);
    check(flags == 8'h10, "R4", "flags after gated sources", flags, 8'h10);
    mclk_en = 1; cmp_en = 1;

    // R3 release waits for a stable clock
    stable = 0;
    @(negedge clk); src = 8'h08;
    repeat (2) @(negedge clk);
    src = 8'h00;
    push(8'h08, 1'b0, 31);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 25) check(sys_rst == 1'b1, "R3", "held while unstable", sys_rst, 1);
    end
    stable = 1;
    wait_idle();

    // R6 a source arriving during the hold is added
    @(negedge clk); src = 8'h02;
    repeat (2) @(negedge clk);
    src = 8'h00;
    repeat (5) @(negedge clk);
    src = 8'h08;
    repeat (2) @(negedge clk);
    src = 8'h00;
    push(8'h0A, 1'b1, LAT_HW);
    wait_idle();

    // R7 power-on replaces earlier flags
    fire(8'h01, 3, 8'h01, 1'b1, "power-on again");

    check(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule